// File: doc/BRIEF.md
# Ring Cellular Automaton Display Engine

The block evolves a one-dimensional cellular automaton of `N` cells arranged in a closed ring and shows the current generation on an LED-style output vector. An internal prescaler raises a one-clock advance tick once every `DIV+1` system clocks. It is a clock enable, not a derived clock. On each tick every cell is recomputed at the same moment from its two ring neighbours, and every cell reads the generation that came before.

The output is a wire copy of the state register. It therefore holds a generation steady for the whole interval between ticks and never goes blank.

When the ring dies out (all cells zero), the next clock reloads it with a seed instead of evolving it. A parameter picks the seed source:
- a free-running `N`-bit shift-feedback register, which falls back to the fixed start pattern if it ever reads zero, or
- the fixed start pattern.

Reset is active-low and synchronous. Everything runs in one clock domain.

Top module: `ring_ca_engine`

## Requirements
- R1: While `rstN` is low at a clock edge, the state loads `INIT_PATTERN` (default `8'b00100100`, bit 7 on the left) and the shift register loads a value with only bit `N-1` set. The output shows that pattern after the edge.
- R2: `genTick` is high for exactly one clock out of every `DIV+1`. The prescaler restarts from zero at reset, so the first tick follows `DIV` clocks after the reset edge.
- R3: The ring wraps. Cell 0 has neighbours `N-1` and 1, and cell `N-1` has neighbours `N-2` and 0.
- R4: On a tick, a cell with no live neighbour keeps its value, a cell with exactly one live neighbour becomes 1, and a cell with two live neighbours becomes 0.
- R5: All cells update together from the previous generation. No new value is seen by a neighbour within the same tick.
- R6: With the state non-zero and no tick, `ledOut` does not change.
- R7: If the state is all zeros at a clock edge (reset high), it is reloaded with the seed at that edge, whether or not a tick is present. The reload takes priority over evolution.
- R8: On each tick, the shift register moves left by one bit and its new bit 0 is bit `N-1` XOR bit `N-2`. With `USE_LFSR=1`, a reload uses the register's value from before that edge.
- R9: With `USE_LFSR=0`, a reload always uses `INIT_PATTERN`.
- R10: Reset is sampled synchronously and overrides reload and evolution, including in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| ledOut | output | N | Current generation, one bit per cell |
| genTick | output | 1 | One-clock advance tick from the prescaler |

## Verification
The hardest condition to reach from the ports is an empty ring, because the state cannot be loaded directly. The stimulus exploits the fact that the default start pattern dies out naturally: it reaches all ones after four generations and then all zeros after the fifth. With `DIV=3`, a long run therefore passes through several reloads. In the shift-register variant each reload takes a different seed, which drives the ring into further patterns. A cycle-accurate reference model predicts every reload, and a second instance with `USE_LFSR=0` covers the fixed-seed path. A mid-run reset checks that reset takes priority.

// File: rtl/ring_ca_pkg.sv
package ring_ca_pkg;

  // Strobes from control to datapath; priority clear > reload > advance
  typedef struct packed {
    logic clear;
    logic reload;
    logic advance;
  } ca_ctrl_t;

endpackage

// File: rtl/ring_ca_ctrl.sv
module ring_ca_ctrl
  import ring_ca_pkg::*;
#(
  parameter int DIV = 25_000_000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ringEmpty,
  output ca_ctrl_t ctl
);
  localparam int CW = (DIV < 1) ? 1 : $clog2(DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV);

  logic [CW-1:0] preCnt;
  logic          atLast;

  assign atLast = (preCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN || atLast) preCnt <= '0;
    else                 preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    ctl.clear   = !rstN;
    ctl.reload  = rstN && ringEmpty;
    ctl.advance = rstN && atLast;
  end

  // R2: tick lasts one clock
  a_r2_single_tick: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> !ctl.advance);

  // R2: counter never exceeds its terminal value
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= LAST);

endmodule

// File: rtl/ring_ca_datapath.sv
module ring_ca_datapath
  import ring_ca_pkg::*;
#(
  parameter int           N            = 8,
  parameter logic [N-1:0] INIT_PATTERN = N'('b00100100),
  parameter bit           USE_LFSR     = 1'b1
) (
  input  logic         clk,
  input  ca_ctrl_t     ctl,
  output logic [N-1:0] cells,
  output logic         ringEmpty
);
  localparam logic [N-1:0] LFSR_INIT = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] nextCells;
  logic [N-1:0] lfsr;
  logic [N-1:0] seed;

  // per-cell rule, all from the current generation
  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam int LEFT  = (i + N - 1) % N;
    localparam int RIGHT = (i + 1) % N;
    logic [1:0] nbr;
    assign nbr = {cells[LEFT], cells[RIGHT]};
    always_comb begin
      case (nbr)
        2'b00:   nextCells[i] = cells[i];
        2'b11:   nextCells[i] = 1'b0;
        default: nextCells[i] = 1'b1;
      endcase
    end
  end

  if (USE_LFSR) begin : g_seed_lfsr
    assign seed = (lfsr != '0) ? lfsr : INIT_PATTERN;
  end else begin : g_seed_fixed
    assign seed = INIT_PATTERN;
  end

  assign ringEmpty = (cells == '0);

  always_ff @(posedge clk) begin
    if (ctl.clear)        cells <= INIT_PATTERN;
    else if (ctl.reload)  cells <= seed;
    else if (ctl.advance) cells <= nextCells;
  end

  always_ff @(posedge clk) begin
    if (ctl.clear)        lfsr <= LFSR_INIT;
    else if (ctl.advance) lfsr <= {lfsr[N-2:0], lfsr[N-1] ^ lfsr[N-2]};
  end

  // R1: reset loads the start pattern
  a_r1_init: assert property (@(posedge clk)
    ctl.clear |=> (cells == INIT_PATTERN));

  // R6: no tick, non-empty ring -> held
  a_r6_hold: assert property (@(posedge clk) disable iff (ctl.clear)
    (!ctl.advance && !ringEmpty) |=> $stable(cells));

  // R7: an empty ring never survives a clock
  a_r7_reload: assert property (@(posedge clk) disable iff (ctl.clear)
    ringEmpty |=> !ringEmpty);

  // R3, R4: cell 0 with both wrapped neighbours live dies
  a_r3_wrap_kill: assert property (@(posedge clk) disable iff (ctl.clear)
    (ctl.advance && !ringEmpty && cells[N-1] && cells[1]) |=> !cells[0]);

  // R8: shift register never locks up at zero
  a_r8_lfsr_live: assert property (@(posedge clk) disable iff (ctl.clear)
    lfsr != '0);

endmodule

// File: rtl/ring_ca_engine.sv
module ring_ca_engine
  import ring_ca_pkg::*;
#(
  parameter int           N            = 8,
  parameter int           DIV          = 25_000_000,
  parameter logic [N-1:0] INIT_PATTERN = N'('b00100100),
  parameter bit           USE_LFSR     = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  output logic [N-1:0] ledOut,
  output logic         genTick
);
  ca_ctrl_t     ctl;
  logic         ringEmpty;
  logic [N-1:0] cells;

  ring_ca_ctrl #(.DIV(DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .ringEmpty(ringEmpty), .ctl(ctl)
  );

  ring_ca_datapath #(.N(N), .INIT_PATTERN(INIT_PATTERN), .USE_LFSR(USE_LFSR)) u_dp (
    .clk(clk), .ctl(ctl), .cells(cells), .ringEmpty(ringEmpty)
  );

  assign ledOut  = cells;
  assign genTick = ctl.advance;

endmodule

// File: tb/ring_ca_engine_bench.sv
module ring_ca_engine_bench;
  localparam int N   = 8;
  localparam int DIV = 3;
  localparam logic [7:0] INIT = 8'b00100100;

  typedef struct {
    logic [7:0] leds;
    logic       tick;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] ledA, ledB;
  logic tickA, tickB;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  exp_t q0[$];
  exp_t q1[$];
  logic [7:0] mSt [2];
  logic [7:0] mLf [2];
  int mCnt [2];
  int reloads [2];
  int lastTick = -1;
  int cyc = 0;

  always #5 clk = ~clk;

  ring_ca_engine #(.N(N), .DIV(DIV), .USE_LFSR(1'b1)) u_ring_ca_engine (
    .clk(clk), .rstN(rstN), .ledOut(ledA), .genTick(tickA)
  );
  ring_ca_engine #(.N(N), .DIV(DIV), .USE_LFSR(1'b0)) u_ring_ca_engine_fixed (
    .clk(clk), .rstN(rstN), .ledOut(ledB), .genTick(tickB)
  );

  // reference rule: R3 wrap, R4 rule, R5 snapshot
  function automatic logic [7:0] evolve(input logic [7:0] s);
    logic [7:0] r;
    for (int i = 0; i < N; i++) begin
      int cnt;
      cnt = int'(s[(i + N - 1) % N]) + int'(s[(i + 1) % N]);
      r[i] = (cnt == 0) ? s[i] : (cnt == 1);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, expv);
    end
  endtask

  // driver: model each edge and push expected outputs
  task automatic modelEdge(input int k, input logic rs);
    exp_t e;
    logic adv;
    e.tag = "R6";
    if (!rs) begin
      mSt[k] = INIT; mLf[k] = 8'h80; mCnt[k] = 0; e.tag = "R1,R10";
    end else begin
      adv = (mCnt[k] == DIV);
      if (mSt[k] == 8'h00) begin
        mSt[k] = (k == 0 && mLf[k] != 0) ? mLf[k] : INIT;
        reloads[k]++;
        e.tag = (k == 0) ? "R7,R8" : "R7,R9";
      end else if (adv) begin
        mSt[k] = evolve(mSt[k]);
        e.tag = "R3,R4,R5";
      end
      if (adv) mLf[k] = {mLf[k][6:0], mLf[k][7] ^ mLf[k][6]};
      mCnt[k] = adv ? 0 : mCnt[k] + 1;
    end
    e.leds = mSt[k];
    e.tick = rs && (mCnt[k] == DIV);
    if (k == 0) q0.push_back(e); else q1.push_back(e);
  endtask

  always @(posedge clk) begin
    modelEdge(0, rstN);
    modelEdge(1, rstN);
  end

  // monitor: pop and compare away from the edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    cyc++;
    if (q0.size() > 0) begin
      e = q0.pop_front();
      check(e.tag, ledA, e.leds);
      check("R2", {7'd0, tickA}, {7'd0, e.tick});
    end
    if (q1.size() > 0) begin
      e = q1.pop_front();
      check(e.tag, ledB, e.leds);
      check("R2", {7'd0, tickB}, {7'd0, e.tick});
    end
    // R2: spacing between ticks
    if (!rstN) lastTick = -1;
    else if (tickA) begin
      if (lastTick >= 0) check("R2 period", 8'(cyc - lastTick), 8'(DIV + 1));
      lastTick = cyc;
    end
  end

  initial begin
    reloads[0] = 0; reloads[1] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset pattern", ledA, INIT);
    check("R1 reset pattern fixed", ledB, INIT);
    rstN = 1'b1;
    repeat (400) @(negedge clk);
    // R10: mid-run reset
    rstN = 1'b0;
    @(negedge clk);
    check("R10 mid-run reset", ledA, INIT);
    check("R10 mid-run reset fixed", ledB, INIT);
    rstN = 1'b1;
    repeat (300) @(negedge clk);
    check("R7 reload count >=2", 8'(reloads[0] >= 2), 8'd1);
    check("R9 reload count >=2", 8'(reloads[1] >= 2), 8'd1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(200000 * 10);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule